// File: doc/BRIEF.md
# Two-Digit Cascaded Rate Multiplier

This block turns a free-running clock into a thinned pulse train. The average pulse rate is set by two 4-bit digits. Inside are two rate stages, each a free counter with a bit-weighted match. The high-digit stage counts on every clock. The low-digit stage counts only when the high stage enables it. Each stage gives as many pulses per sixteen of its own counted clocks as its digit value. It places them so that two stages never land on the same enabled slot.

A mode input picks one of two ways to couple the stages.

- **Add mode.** The low stage advances once per sixteen clocks, in the high stage's wrap slot. The two pulse streams are merged. Over 256 clocks this gives 16·H + L pulses.
- **Multiply mode.** The low stage advances only on the high stage's pulses, and only the low stage drives the output. Over 256 clocks this gives H·L pulses.

A synchronous clear zeroes both counters. The 256-clock frame therefore starts at a known point.

Top module: `rate_mult2`

## Requirements
- R1: While `rst_n` is low, `pulse_o` is 0. In the cycle after a clock edge that samples `clr` high, `pulse_o` is 0 and both stage counters restart at zero.
- R2: With `mul_mode` = 0 and the digits held steady, `pulse_o` is high in exactly 16·`dig_hi` + `dig_lo` of the 256 cycles that follow a clear.
- R3: With `mul_mode` = 1 and the digits held steady, `pulse_o` is high in exactly `dig_hi`·`dig_lo` of the 256 cycles that follow a clear.
- R4: Take phase to be the clock count since clear, mod 16. In add mode with `dig_hi` = 15, every cycle of non-zero phase produces a pulse, one cycle later.
- R5: In add mode, low-digit pulses occupy only the phase-0 slot. With `dig_hi` = 0, pulses appear only in the outputs of cycles whose phase is 0, that is at offsets 0, 16, 32, … after clear.
- R6: If `dig_hi` is 0 in multiply mode, or `dig_lo` is 0 in multiply mode, or both digits are 0 in either mode, then the output that follows is 0.
- R7: Without a further clear, a second consecutive 256-cycle frame gives the same pulse count as the first.
- R8: A clear issued partway through a frame, possibly with new digits, realigns the block. The next 256 cycles then give the exact count for the new digits and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both stages |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of both stage counters and the output |
| mul_mode | input | 1 | 0 = add fractions, 1 = multiply fractions |
| dig_hi | input | W | High-order digit (sixteenths) |
| dig_lo | input | W | Low-order digit |
| pulse_o | output | 1 | Registered combined pulse output |

## Verification
The hardest situation to reach from the ports is an exact count with a partly used low stage. In multiply mode the low counter only moves on high-stage pulses, so its position depends on the whole history since the last clear. The exhaustive sweep therefore clears before every digit pair and counts over an aligned frame. Random trials then abandon a frame at a random depth, change the digits and the mode, and clear again. This exercises realignment from an arbitrary low-counter state.

// File: rtl/rate_mult2.sv
module rate_mult2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         mul_mode,
  input  logic [W-1:0] dig_hi,
  input  logic [W-1:0] dig_lo,
  output logic         pulse_o
);

  logic [W-1:0] hi_cnt, lo_cnt;
  logic hi_hit, hi_wrap, lo_en, lo_hit, nxt;

  function automatic logic slot_hit(input logic [W-1:0] cnt, input logic [W-1:0] dig);
    logic h;
    h = 1'b0;
    for (int i = W - 1; i >= 0; i--)
      if (cnt[i]) h = dig[W-1-i];
    return h;
  endfunction

  assign hi_hit  = slot_hit(hi_cnt, dig_hi);
  assign hi_wrap = (hi_cnt == '0);
  assign lo_en   = mul_mode ? hi_hit : hi_wrap;
  assign lo_hit  = lo_en & slot_hit(lo_cnt, dig_lo);
  assign nxt     = mul_mode ? lo_hit : (hi_hit | lo_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      lo_cnt  <= '0;
      pulse_o <= 1'b0;
    end else if (clr) begin
      hi_cnt  <= '0;
      lo_cnt  <= '0;
      pulse_o <= 1'b0;
    end else begin
      hi_cnt  <= hi_cnt + W'(1);
      if (lo_en) lo_cnt <= lo_cnt + W'(1);
      pulse_o <= nxt;
    end
  end

endmodule

// File: rtl/rate_mult2_chk.sv
module rate_mult2_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         mul_mode,
  input logic [W-1:0] dig_hi,
  input logic [W-1:0] dig_lo,
  input logic         pulse_o
);

  logic [W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   phase <= '0;
    else if (clr) phase <= '0;
    else          phase <= phase + W'(1);

  a_r1_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pulse_o);

  a_r4_full_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !mul_mode && dig_hi == '1 && phase != '0) |=> pulse_o);

  a_r5_wrap_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!mul_mode && dig_lo == '0 && phase == '0) |=> !pulse_o);

  a_r6_zero_digit: assert property (@(posedge clk) disable iff (!rst_n)
    ((mul_mode && (dig_hi == '0 || dig_lo == '0)) || (dig_hi == '0 && dig_lo == '0)) |=> !pulse_o);

endmodule

bind rate_mult2 rate_mult2_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .mul_mode(mul_mode),
  .dig_hi(dig_hi), .dig_lo(dig_lo), .pulse_o(pulse_o)
);

// File: tb/rate_mult2_tb.sv
module rate_mult2_tb;
  localparam int W = 4;
  localparam int FRAME = 1 << (2 * W);

  logic clk = 0, rst_n = 0, clr = 0, mul_mode = 0;
  logic [W-1:0] dig_hi = '0, dig_lo = '0;
  logic pulse_o;
  int compared = 0, mismatched = 0;
  int pos_bad;

  always #4 clk = ~clk;

  rate_mult2 #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mul_mode(mul_mode),
    .dig_hi(dig_hi), .dig_lo(dig_lo), .pulse_o(pulse_o)
  );

  function automatic int expect_cnt(input logic m, input int h, input int l);
    return m ? h * l : 16 * h + l;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
  endtask

  task automatic count_frame(output int n);
    n = 0;
    pos_bad = 0;
    for (int k = 0; k < FRAME; k++) begin
      @(negedge clk);
      if (pulse_o) begin
        n++;
        if (k % 16 != 0) pos_bad++;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n, n2, e;
    void'($urandom(32'd2024));
    dig_hi = 4'd15; dig_lo = 4'd15;
    repeat (3) @(negedge clk);
    check(pulse_o == 0, "R1 reset", pulse_o, 0);
    rst_n = 1;

    // R1: clear forces the output low
    repeat (5) @(negedge clk);
    do_clear();
    check(pulse_o == 0, "R1 clear", pulse_o, 0);

    // R2 / R3 / R6: every digit pair in both modes
    for (int m = 0; m < 2; m++)
      for (int h = 0; h < 16; h++)
        for (int l = 0; l < 16; l++) begin
          mul_mode = m[0]; dig_hi = h[W-1:0]; dig_lo = l[W-1:0];
          do_clear();
          count_frame(n);
          e = expect_cnt(m[0], h, l);
          check(n == e, m ? "R3 mul count" : "R2 add count", n, e);
          if (m == 1 && (h == 0 || l == 0)) check(n == 0, "R6 zero digit", n, 0);
        end

    // R4: full high digit in add mode
    mul_mode = 0; dig_hi = 4'd15; dig_lo = 4'd0;
    do_clear();
    count_frame(n);
    check(n == 240, "R4 full high", n, 240);

    // R5: low pulses only at phase-0 slots
    dig_hi = 4'd0; dig_lo = 4'd15;
    do_clear();
    count_frame(n);
    check(n == 15 && pos_bad == 0, "R5 slot position", pos_bad, 0);

    // R7: consecutive frames repeat
    mul_mode = 1; dig_hi = 4'd11; dig_lo = 4'd13;
    do_clear();
    count_frame(n);
    count_frame(n2);
    check(n == 143, "R3 mul 11x13", n, 143);
    check(n2 == n, "R7 second frame", n2, n);
    mul_mode = 0;
    do_clear();
    count_frame(n);
    count_frame(n2);
    check(n == 189, "R2 add 11,13", n, 189);
    check(n2 == n, "R7 second frame add", n2, n);

    // R8: random partial frames, then clear with new settings
    for (int t = 0; t < 20; t++) begin
      mul_mode = $urandom_range(0, 1);
      dig_hi = W'($urandom_range(0, 15));
      dig_lo = W'($urandom_range(0, 15));
      repeat ($urandom_range(1, 300)) @(negedge clk);
      mul_mode = $urandom_range(0, 1);
      dig_hi = W'($urandom_range(0, 15));
      dig_lo = W'($urandom_range(0, 15));
      do_clear();
      count_frame(n);
      e = expect_cnt(mul_mode, int'(dig_hi), int'(dig_lo));
      check(n == e, "R8 realign", n, e);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule